// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This peripheral holds two independent down-counters behind a small 32-bit register bus. The width of each counter is a parameter, 32 bits by default. Each channel has a value register that counts down and a reload register. A single control register holds, for each channel, one bit that starts the channel and one bit that selects auto-reload.

With auto-reload on, a channel that reaches zero restarts from its reload value, so it produces a steady tick. A reload value of N-1 gives one expiry every N clocks. With auto-reload off, the channel runs down once and then stops at zero. It clears its own start bit, so software can arm a single delayed event by writing a delta and then setting the start bit.

Each expiry produces a one-cycle pulse on that channel's interrupt output. A channel loaded with all-ones in both registers, with reload on, runs free. The bitwise inverse of its value then reads as a timestamp that counts up.

Top module: `dual_reload_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and both interrupt outputs are low.
- R2: Control register fields: bit 0 starts channel 0, bit 1 turns on auto-reload for channel 0, bit 2 starts channel 1, bit 3 turns on auto-reload for channel 1. Bits 31 to 4 are ignored on write and read as zero.
- R3: Register offsets on the byte address: control 0x00, channel 0 reload 0x10, channel 0 value 0x14, channel 1 reload 0x18, channel 1 value 0x1C. Any other offset reads zero. Read data is combinational from the address.
- R4: A started channel whose value is not zero decrements by one on each clock. A stopped channel holds its value.
- R5: A channel expires on a clock edge where it is started and its value is zero. Its interrupt output (bit 0 for channel 0, bit 1 for channel 1) is high for exactly the cycle that follows that edge.
- R6: On expiry with auto-reload on, the value loads the reload register. With reload N-1, expiries come every N clocks.
- R7: On expiry with auto-reload off, the value stays at zero and the channel's start bit clears, so a delta D written before starting gives exactly one expiry.
- R8: A bus write to a value register takes priority over a decrement or reload in the same cycle.
- R9: A bus write to the control register takes priority over the automatic clearing of a start bit in the same cycle.
- R10: The two channels are independent: activity on one never changes the other's registers or interrupt.
- R11: With all-ones in both the value and reload registers and auto-reload on, the inverted value counts up by one per clock from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_irq | output | 2 | One-cycle expiry pulse per channel |

## Verification
The assertions assume that the bus carries a known address and data whenever the write strobe is high. They also assume that the strobe is never unknown after reset. The bench drives every bus input from tasks on the falling clock edge, so the inputs are always defined and stable at the rising edge. Random writes keep values and reloads small, so channels expire often and expiries land in the same cycle as bus writes. Random control words still carry arbitrary upper bits to exercise the ignored field.

// File: rtl/drt_pkg.sv
// Package: shared constants for the dual reload timer.
// Assumes a byte-addressed register window of 32 bytes with word-aligned registers.
package drt_pkg;
    localparam int CH_COUNT  = 2;              // channels sharing one control word
    localparam int CTRL_BITS = 2 * CH_COUNT;   // start + reload bit per channel
    localparam int CTRL_OFS  = 0;              // control register offset
    localparam int CH_BASE   = 16;             // first channel's reload offset
    localparam int CH_STRIDE = 8;              // byte distance between channels
    localparam int VAL_OFS   = 4;              // value offset relative to reload
endpackage

// File: rtl/drt_channel.sv
// Module: one down-counting channel with its value and reload registers.
// Assumes start/reload controls come from the shared control register and
// that at most one of val_we / rld_we is asserted per cycle.
module drt_channel #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              auto_rld,
    input  logic              val_we,
    input  logic              rld_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic [DATA_W-1:0] reload,
    output logic              expire,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ZERO = '0;

    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] reload_q;
    logic              irq_q;

    // Expiry: running and already at zero on this edge.
    assign expire = run && (value_q == ZERO);

    // Counter update: bus write first, then expiry handling, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= ZERO;
        end else if (val_we) begin
            value_q <= wdata;
        end else if (expire) begin
            value_q <= auto_rld ? reload_q : ZERO;
        end else if (run) begin
            value_q <= value_q - ONE;
        end
    end

    // Reload register: plain bus-written storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= ZERO;
        end else if (rld_we) begin
            reload_q <= wdata;
        end
    end

    // Interrupt pulse: registered copy of the expiry strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= expire;
        end
    end

    assign value  = value_q;
    assign reload = reload_q;
    assign irq    = irq_q;

    // R8
    val_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_we |=> (value == $past(wdata)));

    // R6
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_rld && !val_we) |=> (value == $past(reload)));

    // R7
    oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_rld && !val_we) |=> (value == ZERO));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !val_we) |=> $stable(value));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !expire && !val_we) |=> (value == $past(value) - ONE));

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !expire |=> !irq);
endmodule

// File: rtl/drt_ctrl.sv
// Module: shared control register holding start and auto-reload bits.
// Assumes bit 2i starts channel i and bit 2i+1 selects its auto-reload;
// a bus write wins over the hardware clear of a start bit.
module drt_ctrl #(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [2*NCH-1:0] wdata,
    input  logic [NCH-1:0]   expire,
    output logic [2*NCH-1:0] ctrl
);
    logic [2*NCH-1:0] ctrl_q;
    logic [2*NCH-1:0] clear_mask;

    // Build the mask of start bits that expiring one-shot channels drop.
    always_comb begin
        clear_mask = '0;
        for (int i = 0; i < NCH; i++) begin
            clear_mask[2*i] = expire[i] && !ctrl_q[2*i+1];
        end
    end

    // Control storage: bus write overrides the hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we) begin
            ctrl_q <= wdata;
        end else begin
            ctrl_q <= ctrl_q & ~clear_mask;
        end
    end

    assign ctrl = ctrl_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R7
        start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!we && expire[g] && !ctrl[2*g+1]) |=> !ctrl[2*g]);

        // R9
        wr_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (ctrl[2*g] == $past(wdata[2*g])));
    end
endmodule

// File: rtl/drt_rdmux.sv
// Module: combinational read-back selection over the register window.
// Assumes word-aligned offsets from drt_pkg; unmapped offsets return zero.
module drt_rdmux
    import drt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [CTRL_BITS-1:0]       ctrl,
    input  logic [CH_COUNT*DATA_W-1:0] values,
    input  logic [CH_COUNT*DATA_W-1:0] reloads,
    output logic [DATA_W-1:0]          rdata
);
    // Select the register addressed; control bits are zero-extended.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            rdata = DATA_W'(ctrl);
        end
        for (int i = 0; i < CH_COUNT; i++) begin
            if (addr == ADDR_W'(CH_BASE + i * CH_STRIDE)) begin
                rdata = reloads[i*DATA_W +: DATA_W];
            end
            if (addr == ADDR_W'(CH_BASE + i * CH_STRIDE + VAL_OFS)) begin
                rdata = values[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/dual_reload_timer.sv
// Module: top of the dual reload timer; decodes bus writes and wires
// two channels to the shared control register and the read mux.
// Assumes one single-cycle write per asserted bus_we and byte offsets.
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [CH_COUNT-1:0] tick_irq
);
    logic [CTRL_BITS-1:0]       ctrl;
    logic [CH_COUNT-1:0]        expire;
    logic [CH_COUNT*DATA_W-1:0] values;
    logic [CH_COUNT*DATA_W-1:0] reloads;
    logic                       ctrl_we;

    assign ctrl_we = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));

    drt_ctrl #(.NCH(CH_COUNT)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .wdata  (bus_wdata[CTRL_BITS-1:0]),
        .expire (expire),
        .ctrl   (ctrl)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] RLD_A = ADDR_W'(CH_BASE + g * CH_STRIDE);
        localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(CH_BASE + g * CH_STRIDE + VAL_OFS);
        logic val_we;
        logic rld_we;

        assign val_we = bus_we && (bus_addr == VAL_A);
        assign rld_we = bus_we && (bus_addr == RLD_A);

        drt_channel #(.DATA_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (ctrl[2*g]),
            .auto_rld (ctrl[2*g+1]),
            .val_we   (val_we),
            .rld_we   (rld_we),
            .wdata    (bus_wdata),
            .value    (values[g*DATA_W +: DATA_W]),
            .reload   (reloads[g*DATA_W +: DATA_W]),
            .expire   (expire[g]),
            .irq      (tick_irq[g])
        );
    end

    drt_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
        .addr    (bus_addr),
        .ctrl    (ctrl),
        .values  (values),
        .reloads (reloads),
        .rdata   (bus_rdata)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (tick_irq == '0));
endmodule

// File: tb/dual_reload_timer_tb.sv
module dual_reload_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_RLD0 = 5'h10;
    localparam logic [4:0] A_VAL0 = 5'h14;
    localparam logic [4:0] A_RLD1 = 5'h18;
    localparam logic [4:0] A_VAL1 = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  tick_irq;

    int checks = 0;
    int errors = 0;
    bit irq_watch = 1'b0;
    bit done = 1'b0;

    // Reference state built from the requirements.
    logic [3:0]  m_ctrl;
    logic [31:0] m_val [2];
    logic [31:0] m_rld [2];
    logic [1:0]  m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_reload_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_irq  (tick_irq)
    );

    function automatic logic [4:0] val_addr(int ch);
        return ch == 0 ? A_VAL0 : A_VAL1;
    endfunction

    function automatic logic [4:0] rld_addr(int ch);
        return ch == 0 ? A_RLD0 : A_RLD1;
    endfunction

    // Reference model update per clock edge (R4..R9).
    always @(posedge clk) begin
        logic [3:0]  n_ctrl;
        logic [1:0]  n_irq;
        logic [31:0] n_val;
        logic        ex;
        if (!rst_n) begin
            m_ctrl = '0; m_irq = '0;
            for (int i = 0; i < 2; i++) begin m_val[i] = '0; m_rld[i] = '0; end
        end else begin
            n_ctrl = m_ctrl;
            for (int i = 0; i < 2; i++) begin
                ex = m_ctrl[2*i] && (m_val[i] == 0);
                n_irq[i] = ex;
                n_val = m_val[i];
                if (bus_we && bus_addr == val_addr(i)) n_val = bus_wdata;
                else if (ex) n_val = m_ctrl[2*i+1] ? m_rld[i] : 32'd0;
                else if (m_ctrl[2*i]) n_val = m_val[i] - 32'd1;
                if (ex && !m_ctrl[2*i+1]) n_ctrl[2*i] = 1'b0;
                if (bus_we && bus_addr == rld_addr(i)) m_rld[i] = bus_wdata;
                m_val[i] = n_val;
            end
            if (bus_we && bus_addr == A_CTRL) n_ctrl = bus_wdata[3:0];
            m_ctrl = n_ctrl;
            m_irq = n_irq;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Interrupt comparison every cycle against the model (R5, R10).
    always @(negedge clk) begin
        if (rst_n && irq_watch) check("R5 R10 irq vs model", {30'd0, tick_irq}, {30'd0, m_irq});
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] model_read(logic [4:0] a);
        case (a)
            A_CTRL: return {28'd0, m_ctrl};
            A_RLD0: return m_rld[0];
            A_VAL0: return m_val[0];
            A_RLD1: return m_rld[1];
            A_VAL1: return m_val[1];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [4:0] pick_addr(int unsigned r);
        case (r % 8)
            0, 1: return A_CTRL;
            2: return A_RLD0;
            3: return A_VAL0;
            4: return A_RLD1;
            5: return A_VAL1;
            6: return 5'h04;
            default: return 5'h0C;
        endcase
    endfunction

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a0, a1;
        int gap, pulses;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        #1 check("R1 irq after reset", {30'd0, tick_irq}, 32'd0);
        rst_n = 1'b1;
        rd(A_CTRL, d); check("R1 ctrl reset", d, 32'd0);
        rd(A_RLD0, d); check("R1 reload0 reset", d, 32'd0);
        rd(A_VAL0, d); check("R1 value0 reset", d, 32'd0);
        rd(A_RLD1, d); check("R1 reload1 reset", d, 32'd0);
        rd(A_VAL1, d); check("R1 value1 reset", d, 32'd0);
        irq_watch = 1'b1;

        // R2: upper control bits ignored; R3: unmapped offset reads zero.
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, d); check("R2 ctrl upper bits", d, 32'd0);
        wr(A_RLD0, 32'h1234_5678);
        rd(5'h04, d); check("R3 unmapped offset", d, 32'd0);
        rd(A_RLD0, d); check("R3 reload0 offset", d, 32'h1234_5678);

        // R10 and R4: stopped channel 1 holds while channel 0 ticks.
        wr(A_VAL1, 32'd7);
        // R6: reload 4 gives a period of 5 clocks.
        wr(A_RLD0, 32'd4);
        wr(A_VAL0, 32'd4);
        wr(A_CTRL, 32'h3);
        gap = 0;
        while (tick_irq[0] !== 1'b1 && gap < 50) begin @(negedge clk); gap++; end
        gap = 0;
        do begin @(negedge clk); gap++; end while (tick_irq[0] !== 1'b1 && gap < 50);
        check("R6 period with reload 4", gap, 32'd5);
        rd(A_VAL1, d); check("R10 R4 channel1 untouched", d, 32'd7);

        // R8 and R4: value write wins, then decrements by one.
        wr(A_RLD0, 32'd100);
        wr(A_VAL0, 32'd50);
        rd(A_VAL0, d); check("R8 value write priority", d, 32'd50);
        rd(A_VAL0, d); check("R4 decrement by one", d, 32'd49);

        // R7: one-shot on channel 1 gives a single pulse and stops.
        wr(A_CTRL, 32'h0);
        wr(A_VAL1, 32'd3);
        wr(A_CTRL, 32'h4);
        pulses = 0;
        repeat (20) begin @(negedge clk); if (tick_irq[1] === 1'b1) pulses++; end
        check("R7 one-shot pulse count", pulses, 32'd1);
        rd(A_CTRL, d); check("R7 start bit cleared", d, 32'd0);
        rd(A_VAL1, d); check("R7 value rests at zero", d, 32'd0);

        // R9: control write on the expiry edge keeps the start bit.
        wr(A_VAL1, 32'd0);
        wr(A_CTRL, 32'h4);
        wr(A_CTRL, 32'h4);
        rd(A_CTRL, d); check("R9 control write beats clear", d, 32'h4);

        // R11: free-running channel gives an up-counting inverse.
        wr(A_CTRL, 32'h0);
        wr(A_VAL0, 32'hFFFF_FFFF);
        wr(A_RLD0, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h3);
        rd(A_VAL0, a0);
        rd(A_VAL0, a1);
        check("R11 inverse start", ~a0, 32'd0);
        check("R11 inverse step", ~a1, 32'd1);

        // Random mix of writes, reads and idle cycles against the model.
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            logic [4:0] a;
            r = $urandom;
            a = pick_addr($urandom);
            if (r % 4 == 0) begin
                if (a == A_CTRL) wr(a, $urandom);
                else wr(a, $urandom % 13);
            end else if (r % 4 == 1) begin
                rd(a, d);
                check("R3 R4 R6 R7 R8 R9 random read", d, model_read(a));
            end else begin
                @(negedge clk);
            end
        end

        irq_watch = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule